// File: doc/BRIEF.md
# Remote DMA Channel Controller

This block moves data between a host-side data port and a local packet memory. Software programs a 16-bit start address, a 16-bit byte count and a 3-bit command. From these the channel runs a remote read, which streams memory contents out to the host, or a remote write, which streams host data into memory. It can move single bytes or 16-bit words, and an optional byte swap serves hosts of either endianness. When the count runs out, the channel raises a one-cycle completion event for the interrupt unit. An abort command stops a transfer at once.

Both host streams use valid/ready. On the read stream the channel holds `rd_valid` and `rd_data` steady until the host takes the unit with `rd_ready`. On the write stream the host must hold `wr_data` until the channel accepts it with `wr_ready`. The channel never loses a unit while either side stalls. Packet memory is a synchronous RAM port with one cycle of read latency and byte enables. A single `grant` input from the memory arbiter gates every memory access.

The live address and the remaining count are always visible on `cur_addr` and `cur_count`. An abort leaves both at the values they had reached, so software can see how far the transfer went and is expected to clear the count itself.

Top module: `rdma_channel`

## Requirements
- R1: After reset the channel is idle. `busy`, `dma_done`, `mem_en`, `wr_ready` and `rd_valid` are low, and `cur_addr` and `cur_count` are zero.
- R2: A pulse on `cmd_wr` with `cmd_code` 001 starts a remote read, and with 010 starts a remote write. Either start loads `start_addr` and `byte_count` and samples `word_mode` and `swap_bytes`. Codes 000 and 011 are accepted without effect: the channel stays idle and the address and count are unchanged. While busy, every code other than an abort is ignored.
- R3: During a remote write, each unit accepted on the write stream is written to memory at `cur_addr` in the same cycle. `wr_ready` is never high without `grant`.
- R4: During a remote read, units leave on the read stream in ascending address order. Once `rd_valid` is high, it and `rd_data` hold until `rd_ready` is seen.
- R5: In byte mode each unit is one byte, and the address and count step by 1. A byte at an even address sits on memory bits 7:0 with `mem_be`=01. A byte at an odd address sits on bits 15:8 with `mem_be`=10. A written byte is taken from `wr_data[7:0]`. A read byte is returned in `rd_data[7:0]` with bits 15:8 zero.
- R6: In word mode with an even start address and at least 2 bytes remaining, each unit is one 16-bit word with `mem_be`=11, and the address and count step by 2. Without swap, the byte at the even address is on bits 7:0 of the host data.
- R7: In word mode, when one byte remains, it moves as a single byte with byte-mode lanes, and the count ends at zero.
- R8: With `swap_bytes` set in word mode, the two bytes of each word are exchanged between the host data and memory, in both directions.
- R9: When a running transfer finds its count at zero, `dma_done` pulses for exactly one cycle and `busy` falls. A start with a count of zero completes without any memory access. The count never rises while busy.
- R10: A `cmd_code` with bit 2 set aborts at once. No further memory access takes place, `busy` falls in the next cycle and no `dma_done` is raised. `cur_addr` and `cur_count` keep their advanced values.
- R11: While `grant` is low, `mem_en` stays low. The transfer resumes without losing or repeating data once `grant` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 001 read, 010 write, 1xx abort |
| start_addr | input | 16 | Start byte address, loaded on start |
| byte_count | input | 16 | Byte count, loaded on start |
| word_mode | input | 1 | 1 selects 16-bit transfers |
| swap_bytes | input | 1 | 1 exchanges the bytes of each word |
| grant | input | 1 | Memory access granted by the arbiter |
| wr_data | input | 16 | Host write data |
| wr_valid | input | 1 | Host write data valid |
| wr_ready | output | 1 | Channel accepts write data |
| rd_data | output | 16 | Read data to host |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Host accepts read data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Memory byte lane enables |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after access |
| cur_addr | output | 16 | Current remote address |
| cur_count | output | 16 | Remaining byte count |
| busy | output | 1 | Transfer in progress |
| dma_done | output | 1 | One-cycle completion event |

## Verification
The bound checker watches every cycle for these properties:
- no memory access without grant and no activity while idle;
- read-stream stability under back-pressure;
- a single-cycle completion pulse that only appears with a zero count;
- a count that never rises during a transfer;
- a stopped channel in the cycle after an abort.

Other behaviours can only be shown by the bench's scenarios, which compare memory and stream contents against an independent model:
- the byte-lane placement and the swap;
- the odd final byte in word mode;
- the advanced address and count left by an abort;
- commands being ignored while busy.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_LAT,
    ST_RD_OUT,
    ST_WR
  } rdma_state_e;

  localparam logic [2:0] CMD_READ  = 3'b001;
  localparam logic [2:0] CMD_WRITE = 3'b010;
endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode
  import rdma_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [2:0] cmd_code,
  input  logic       idle,
  output logic       go_read,
  output logic       go_write,
  output logic       abort
);
  // Bit 2 aborts whatever the low bits say; starts are honoured only when idle.
  always_comb begin
    abort    = cmd_wr & cmd_code[2];
    go_read  = cmd_wr & idle & (cmd_code == CMD_READ);
    go_write = cmd_wr & idle & (cmd_code == CMD_WRITE);
  end
endmodule

// File: rtl/rdma_addr_ctr.sv
module rdma_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              advance,
  input  logic              word_mode,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count,
  output logic              wide,
  output logic              zero
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_TWO  = CNT_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TWO = ADDR_W'(2);

  // A word step needs at least two bytes left; otherwise fall back to a byte.
  assign wide = word_mode && (count > CNT_ONE);
  assign zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      count <= '0;
    end else if (load) begin
      addr  <= ld_addr;
      count <= ld_cnt;
    end else if (advance) begin
      addr  <= addr  + (wide ? ADDR_TWO : ADDR_ONE);
      count <= count - (wide ? CNT_TWO  : CNT_ONE);
    end
  end
endmodule

// File: rtl/rdma_lane_mux.sv
module rdma_lane_mux #(
  parameter int BYTE_W = 8
) (
  input  logic              wide,
  input  logic              odd,
  input  logic              swap,
  input  logic [2*BYTE_W-1:0] host_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic [2*BYTE_W-1:0] mem_wdata,
  output logic [1:0]        mem_be,
  output logic [2*BYTE_W-1:0] host_rdata
);
  logic [BYTE_W-1:0] w_lo, w_hi, r_lo, r_hi;

  always_comb begin
    w_lo = host_wdata[BYTE_W-1:0];
    w_hi = host_wdata[2*BYTE_W-1:BYTE_W];
    r_lo = mem_rdata[BYTE_W-1:0];
    r_hi = mem_rdata[2*BYTE_W-1:BYTE_W];
    if (wide) begin
      mem_be     = 2'b11;
      mem_wdata  = swap ? {w_lo, w_hi} : {w_hi, w_lo};
      host_rdata = swap ? {r_lo, r_hi} : {r_hi, r_lo};
    end else begin
      mem_be     = odd ? 2'b10 : 2'b01;
      mem_wdata  = {w_lo, w_lo};
      host_rdata = {{BYTE_W{1'b0}}, (odd ? r_hi : r_lo)};
    end
  end
endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [2:0]          cmd_code,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [CNT_W-1:0]    byte_count,
  input  logic                word_mode,
  input  logic                swap_bytes,
  input  logic                grant,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                wr_valid,
  output logic                wr_ready,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic                mem_en,
  output logic                mem_we,
  output logic [1:0]          mem_be,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic [CNT_W-1:0]    cur_count,
  output logic                busy,
  output logic                dma_done
);
  localparam int DATA_W = 2 * BYTE_W;

  rdma_state_e       state, state_d;
  logic              word_q, swap_q, done_d, done_q;
  logic [DATA_W-1:0] hold_q, rdata_fmt;
  logic              go_read, go_write, abort, idle;
  logic              wide, zero, advance, wr_fire, rd_fire, rd_issue;

  assign idle = (state == ST_IDLE);

  rdma_cmd_decode u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_code (cmd_code),
    .idle     (idle),
    .go_read  (go_read),
    .go_write (go_write),
    .abort    (abort)
  );

  rdma_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go_read | go_write),
    .ld_addr   (start_addr),
    .ld_cnt    (byte_count),
    .advance   (advance),
    .word_mode (word_q),
    .addr      (cur_addr),
    .count     (cur_count),
    .wide      (wide),
    .zero      (zero)
  );

  rdma_lane_mux #(.BYTE_W(BYTE_W)) u_lane (
    .wide       (wide),
    .odd        (cur_addr[0]),
    .swap       (swap_q),
    .host_wdata (wr_data),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .host_rdata (rdata_fmt)
  );

  // Stream handshakes; an abort in the same cycle suppresses any transfer.
  assign wr_ready = (state == ST_WR) && !zero && grant && !abort;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_valid = (state == ST_RD_OUT) && !abort;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_issue = (state == ST_RD_REQ) && !zero && grant && !abort;
  assign advance  = wr_fire | rd_fire;

  assign mem_en   = rd_issue | wr_fire;
  assign mem_we   = wr_fire;
  assign mem_addr = cur_addr;
  assign rd_data  = hold_q;
  assign busy     = !idle;
  assign dma_done = done_q;

  always_comb begin
    state_d = state;
    done_d  = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go_read)       state_d = ST_RD_REQ;
          else if (go_write) state_d = ST_WR;
        end
        ST_RD_REQ: begin
          if (zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (grant) begin
            state_d = ST_RD_LAT;
          end
        end
        ST_RD_LAT: state_d = ST_RD_OUT;
        ST_RD_OUT: if (rd_fire) state_d = ST_RD_REQ;
        ST_WR: begin
          if (zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      word_q <= 1'b0;
      swap_q <= 1'b0;
      hold_q <= '0;
    end else begin
      state  <= state_d;
      done_q <= done_d;
      if (go_read | go_write) begin
        word_q <= word_mode;
        swap_q <= swap_bytes;
      end
      if (state == ST_RD_LAT) hold_q <= rdata_fmt;
    end
  end
endmodule

// File: rtl/rdma_channel_chk.sv
module rdma_channel_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_wr,
  input logic [2:0]          cmd_code,
  input logic                grant,
  input logic                wr_ready,
  input logic [2*BYTE_W-1:0] rd_data,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic                mem_en,
  input logic                mem_we,
  input logic [CNT_W-1:0]    cur_count,
  input logic                busy,
  input logic                dma_done
);
  logic abort_in;
  assign abort_in = cmd_wr && cmd_code[2];

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !wr_ready && !rd_valid));

  p_wr_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> grant);

  p_write_is_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !abort_in) |=> (rd_valid && $stable(rd_data)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done);

  p_done_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> (cur_count == '0 && !busy));

  p_count_falls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cur_count <= $past(cur_count)));

  p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |=> (!busy && !mem_en && !dma_done));

  p_no_access_ungranted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> grant);
endmodule

bind rdma_channel rdma_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_code  (cmd_code),
  .grant     (grant),
  .wr_ready  (wr_ready),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .cur_count (cur_count),
  .busy      (busy),
  .dma_done  (dma_done)
);

// File: tb/rdma_channel_tb.sv
module rdma_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [15:0] start_addr = '0, byte_count = '0;
  logic        word_mode = 1'b0, swap_bytes = 1'b0, grant = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0;
  logic        wr_ready, rd_valid, mem_en, mem_we, busy, dma_done;
  logic [15:0] rd_data, mem_addr, mem_wdata, cur_addr, cur_count;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  mem_be;

  int vectors = 0, errors = 0, cyc = 0;
  int done_cnt = 0, acc_cnt = 0, ungranted = 0;
  logic [7:0] mem [256];
  logic [7:0] sh  [256];

  always #10 clk = ~clk;  // 50 MHz

  rdma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .start_addr(start_addr), .byte_count(byte_count), .word_mode(word_mode),
    .swap_bytes(swap_bytes), .grant(grant), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
    .cur_count(cur_count), .busy(busy), .dma_done(dma_done)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'(i * 37 + 11);
  endfunction

  // Synchronous RAM model, byte lanes: even byte on bits 7:0.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
    end else if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
        if (mem_be[1]) mem[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (dma_done) done_cnt++;
      if (mem_en) acc_cnt++;
      if (mem_en && !grant) ungranted++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] code, input int a, input int n, input bit w, input bit s);
    @(negedge clk);
    cmd_code = code; start_addr = 16'(a); byte_count = 16'(n);
    word_mode = w; swap_bytes = s; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic cmp_mem(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== sh[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic wait_done(input int d0, input string req);
    for (int k = 0; k < 10 && done_cnt == d0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(done_cnt == d0 + 1, req, done_cnt - d0, 1);
    chk(!busy, req, busy, 0);
  endtask

  // Host write stream; inject >= 0 issues a read command mid-transfer (must be ignored).
  task automatic run_write(input int a0, input int n, input bit w, input bit s,
                           input int inject, input string req);
    int off = 0, guard = 0, d0 = done_cnt;
    bit fire, have = 0, injected = 0, step2 = 0;
    logic [15:0] unit = '0;
    logic [7:0] x0 = '0, x1 = '0;
    do_cmd(3'b010, a0, n, w, s);
    while (off < n && guard < 4000) begin
      @(negedge clk);
      cmd_wr = 1'b0;
      guard++;
      if (inject >= 0 && off == inject && !injected) begin
        injected = 1; wr_valid = 1'b0; grant = 1'b1;
        cmd_code = 3'b001; start_addr = 16'h0090; byte_count = 16'd9; cmd_wr = 1'b1;
        @(posedge clk);
        continue;
      end
      if (!have) begin
        x0 = 8'($urandom); x1 = 8'($urandom);
        step2 = w && (n - off >= 2);
        if (step2) unit = s ? {x0, x1} : {x1, x0};
        else       unit = {8'($urandom), x0};
        have = 1;
      end
      grant = ($urandom % 4) != 0;
      wr_valid = ($urandom % 3) != 0;
      wr_data = wr_valid ? unit : 16'($urandom);
      #1;
      fire = wr_valid && wr_ready;
      @(posedge clk);
      if (fire) begin
        sh[(a0 + off) % 256] = x0;
        if (step2) sh[(a0 + off + 1) % 256] = x1;
        off += step2 ? 2 : 1;
        have = 0;
      end
    end
    @(negedge clk);
    wr_valid = 1'b0; cmd_wr = 1'b0;
    wait_done(d0, req);
    chk(cur_addr == 16'(a0 + n), req, cur_addr, a0 + n);
    chk(cur_count == 16'h0, req, cur_count, 0);
    cmp_mem(req);
  endtask

  task automatic run_read(input int a0, input int n, input bit w, input bit s,
                          input int stall, input string req);
    int off = 0, guard = 0, d0 = done_cnt, acc0;
    bit fire, step2;
    logic [15:0] exp;
    do_cmd(3'b001, a0, n, w, s);
    if (stall > 0) begin
      acc0 = acc_cnt;
      grant = 1'b0; rd_ready = 1'b1;
      repeat (stall) @(negedge clk);
      chk(acc_cnt == acc0 && !rd_valid, "R11", acc_cnt - acc0, 0);
    end
    while (off < n && guard < 4000) begin
      @(negedge clk);
      guard++;
      grant = ($urandom % 4) != 0;
      rd_ready = ($urandom % 3) != 0;
      #1;
      fire = rd_valid && rd_ready;
      if (fire) begin
        step2 = w && (n - off >= 2);
        if (step2) exp = s ? {sh[(a0+off)%256], sh[(a0+off+1)%256]}
                           : {sh[(a0+off+1)%256], sh[(a0+off)%256]};
        else       exp = {8'h00, sh[(a0+off)%256]};
        chk(rd_data == exp, req, rd_data, exp);
      end
      @(posedge clk);
      if (fire) off += (w && (n - off >= 2)) ? 2 : 1;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    wait_done(d0, req);
    chk(cur_addr == 16'(a0 + n), req, cur_addr, a0 + n);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    int acc0, d0;
    logic [15:0] a_keep, c_keep;
    for (int i = 0; i < 256; i++) sh[i] = init_byte(i);
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !dma_done && !mem_en, "R1", {busy, dma_done, mem_en}, 0);
    chk(!wr_ready && !rd_valid, "R1", {wr_ready, rd_valid}, 0);
    chk(cur_addr == 0 && cur_count == 0, "R1", {cur_addr, cur_count}, 0);

    // R2 no-op codes 000 and 011
    a_keep = cur_addr; c_keep = cur_count; acc0 = acc_cnt;
    do_cmd(3'b000, 16'h30, 5, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && acc_cnt == acc0 && cur_count == c_keep && cur_addr == a_keep, "R2", {busy, cur_count}, {1'b0, c_keep});
    do_cmd(3'b011, 16'h30, 5, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && acc_cnt == acc0 && cur_count == c_keep, "R2", {busy, cur_count}, {1'b0, c_keep});

    // R5 byte mode, odd start; R6/R7 word mode odd length; R8 swap
    run_write(16'h11, 5, 0, 0, -1, "R5");
    run_read (16'h11, 5, 0, 0, 0, "R5");
    run_write(16'h40, 7, 1, 0, -1, "R7");
    run_read (16'h40, 7, 1, 0, 0, "R6");
    run_write(16'h60, 6, 1, 1, -1, "R8");
    run_read (16'h60, 6, 1, 0, 0, "R8");
    run_read (16'h60, 6, 1, 1, 0, "R8");
    // R2 read command while writing is ignored
    run_write(16'h20, 4, 0, 0, 1, "R2");
    // R11 stall with grant held low
    run_read (16'h50, 3, 0, 0, 10, "R11");

    // R9 zero count completes without access
    acc0 = acc_cnt;
    run_read(16'h10, 0, 1, 0, 0, "R9");
    chk(acc_cnt == acc0, "R9", acc_cnt - acc0, 0);

    // R10 abort mid write
    d0 = done_cnt;
    do_cmd(3'b010, 16'h80, 20, 1, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      grant = 1'b1; wr_valid = 1'b1;
      wr_data = {8'(16'hA1 + 2*k), 8'(16'hA0 + 2*k)};
      sh[16'h80 + 2*k] = 8'(16'hA0 + 2*k);
      sh[16'h81 + 2*k] = 8'(16'hA1 + 2*k);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    do_cmd(3'b101, 16'h00, 0, 0, 0);
    acc0 = acc_cnt;
    chk(!busy, "R10", busy, 0);
    chk(cur_addr == 16'h86, "R10", cur_addr, 16'h86);
    chk(cur_count == 16'd14, "R10", cur_count, 14);
    wr_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk(acc_cnt == acc0 && !wr_ready, "R10", acc_cnt - acc0, 0);
    chk(done_cnt == d0, "R10", done_cnt - d0, 0);
    wr_valid = 1'b0;
    cmp_mem("R10");

    // Random mix
    for (int it = 0; it < 14; it++) begin
      int a = int'($urandom % 64) * 2;
      int n = int'($urandom % 80);
      bit w = 1'($urandom), s = 1'($urandom);
      run_write(a, n, w, s, -1, "R3");
      run_read(a, n, 1'($urandom), 1'($urandom), 0, "R4");
    end

    chk(ungranted == 0, "R11", ungranted, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule